// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a programmable logic device over its slave-serial configuration pins. Once started, it first holds the active-low program line high for one cycle and then drives it low to clear the target. It waits for the target's init pin to fall, releases the program line, and then waits for init to rise again. After that it accepts bitstream bytes from a valid/ready byte stream and shifts each byte out on a data pin, most significant bit first, under a serial clock that it generates. When the byte marked last has been shifted, it waits for the target's done pin. It then applies a short reset through the data pin and reports completion.

Each of the three waits has its own limit, counted in clock cycles. If a wait runs past its limit, the sequence stops and reports that wait's own error code. A start pulse is only accepted while the block is idle. The error code from the last run stays readable until the next start. The byte stream follows the usual back-pressure rules: a byte moves only in a cycle where `in_valid` and `in_ready` are both high. The producer must hold `in_data` and `in_last` stable while `in_valid` is high and `in_ready` is low. `in_ready` is raised only during the streaming phase, and only while the shifter is empty.

Top module: `fpga_cfg_seq`

## Requirements
- R1: After reset: `cfg_prog_n`=1, `cfg_clk`=0, `cfg_data`=0, `busy`=0, `in_ready`=0, `finished`=0, `err_code`=0.
- R2: A `start` pulse while idle sets `busy` in the next cycle. In that cycle `cfg_prog_n` is still 1. From the following cycle `cfg_prog_n` is 0 until `cfg_init` is seen low. `cfg_clk` stays low while `cfg_prog_n` is 0.
- R3: If `cfg_init` stays high for INIT_LO_TMO cycles with `cfg_prog_n` low, the run ends with `err_code`=1. In that case `cfg_prog_n` is low for exactly INIT_LO_TMO cycles.
- R4: If `cfg_init` does not return high within INIT_HI_TMO cycles after `cfg_prog_n` is released, the run ends with `err_code`=2.
- R5: Bytes leave on `cfg_data` MSB first, one bit per `cfg_clk` rising edge. Each `cfg_clk` high phase lasts exactly HALF_CYC cycles, and `cfg_data` does not change while `cfg_clk` is high.
- R6: `in_ready` is high only during the streaming phase, and then only while no byte is being shifted. A byte presented while `in_ready` is low is held, not lost. Gaps in `in_valid` stall the serial clock without corrupting the stream.
- R7: After the byte marked by `in_last` has been shifted, the block waits for `cfg_done`. If `cfg_done` is not high within DONE_TMO cycles, the run ends with `err_code`=3, and no data-pin reset is applied.
- R8: Once `cfg_done` is seen, `cfg_prog_n`=1 and `cfg_clk`=1 for 2×RST_CYC cycles. During that time `cfg_data` is 0 for the first RST_CYC cycles and 1 for the next RST_CYC cycles. The run then ends with `err_code`=0.
- R9: The end of a run is marked by a one-cycle `finished` pulse, in the cycle where `busy` is already low. `err_code` keeps its value until the next accepted start, which clears it to 0.
- R10: A `start` pulse while `busy` is high has no effect: the stream, the error code and the outcome are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run (accepted only when idle) |
| in_data | input | 8 | Bitstream byte |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_last | input | 1 | Byte on `in_data` is the final one |
| in_ready | output | 1 | Block accepts a byte this cycle |
| cfg_prog_n | output | 1 | Active-low program line to the target |
| cfg_init | input | 1 | Init feedback from the target |
| cfg_done | input | 1 | Done feedback from the target |
| cfg_clk | output | 1 | Serial configuration clock |
| cfg_data | output | 1 | Serial configuration data |
| busy | output | 1 | A run is in progress |
| finished | output | 1 | One-cycle pulse at the end of a run |
| err_code | output | 2 | Result of last run: 0 ok, 1 init-low timeout, 2 init-high timeout, 3 done timeout |

## Verification
The bench attaches a behavioural target that captures bits on the rising edges of the serial clock and answers the program, init and done pins after chosen delays, or never. It checks the init-low timeout by counting how many cycles the program line stays low. A timer that is off by one would show up as one cycle too many or too few, and a swapped error code would be read back directly. The streaming tests present a byte before the stream opens, insert gaps in `in_valid`, and fire a second start partway through. A shifter that sent LSB first, dropped a byte taken while `in_ready` was low, or let a stray start restart the run would corrupt the captured bytes or change the reported result. The final data-pin reset is timed phase by phase, so uneven or missing phases are caught. The check that the reset is absent after a done timeout catches a design that falls through to the reset anyway.

// File: rtl/fpga_cfg_pkg.sv
package fpga_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRG_HI,
    ST_PRG_LO,
    ST_WAIT_INIT,
    ST_STREAM,
    ST_WAIT_DONE,
    ST_RST_LO,
    ST_RST_HI
  } cfg_state_t;

  localparam logic [1:0] ERR_NONE      = 2'd0;
  localparam logic [1:0] ERR_INIT_LO   = 2'd1;
  localparam logic [1:0] ERR_INIT_HI   = 2'd2;
  localparam logic [1:0] ERR_DONE      = 2'd3;

endpackage

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = en && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (en && !hit) cnt <= cnt + 1'b1;
  end

  // count never passes the window it is timing
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < limit));

endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] din,
  output logic       idle,
  output logic       byte_done,
  output logic       sclk,
  output logic       sdat
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HW-1:0] HLAST = HW'(HALF - 1);

  logic [7:0]    sreg;
  logic [2:0]    bitn;
  logic [HW-1:0] hcnt;
  logic          phase;
  logic          active;

  assign idle = !active;
  assign sclk = active && phase;
  assign sdat = active && sreg[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0; bitn <= '0; hcnt <= '0;
      phase <= 1'b0; active <= 1'b0; byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (load) begin
        sreg <= din; bitn <= '0; hcnt <= '0;
        phase <= 1'b0; active <= 1'b1;
      end else if (active) begin
        if (hcnt == HLAST) begin
          hcnt <= '0;
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            sreg  <= {sreg[6:0], 1'b0};
            if (bitn == 3'd7) begin
              active    <= 1'b0;
              byte_done <= 1'b1;
            end else begin
              bitn <= bitn + 1'b1;
            end
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  p_data_stable_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdat));

  p_load_when_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active);

endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
  import fpga_cfg_pkg::*;
#(
  parameter int INIT_LO_TMO = 100000,
  parameter int INIT_HI_TMO = 100000,
  parameter int DONE_TMO    = 1000000,
  parameter int HALF_CYC    = 2,
  parameter int RST_CYC     = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic       cfg_prog_n,
  input  logic       cfg_init,
  input  logic       cfg_done,
  output logic       cfg_clk,
  output logic       cfg_data,
  output logic       busy,
  output logic       finished,
  output logic [1:0] err_code
);
  localparam int M1   = (INIT_LO_TMO > INIT_HI_TMO) ? INIT_LO_TMO : INIT_HI_TMO;
  localparam int M2   = (DONE_TMO > RST_CYC) ? DONE_TMO : RST_CYC;
  localparam int LMAX = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(LMAX + 1);

  cfg_state_t     state, nxt;
  logic [1:0]     err_nxt;
  logic           fin_nxt;
  logic           last_q;
  logic [TW-1:0]  limit;
  logic           t_en, t_hit;
  logic           sh_load, sh_idle, sh_done, sh_clk, sh_dat;
  logic           rst_phase;

  // timer window per waiting state
  always_comb begin
    t_en  = 1'b1;
    limit = TW'(1);
    case (state)
      ST_PRG_LO:            limit = TW'(INIT_LO_TMO);
      ST_WAIT_INIT:         limit = TW'(INIT_HI_TMO);
      ST_WAIT_DONE:         limit = TW'(DONE_TMO);
      ST_RST_LO, ST_RST_HI: limit = TW'(RST_CYC);
      default:              t_en  = 1'b0;
    endcase
  end

  cfg_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(nxt != state), .en(t_en),
    .limit(limit), .hit(t_hit)
  );

  always_comb begin
    nxt     = state;
    err_nxt = err_code;
    fin_nxt = 1'b0;
    case (state)
      ST_IDLE:      if (start) nxt = ST_PRG_HI;
      ST_PRG_HI:    nxt = ST_PRG_LO;
      ST_PRG_LO: begin
        if (!cfg_init) nxt = ST_WAIT_INIT;
        else if (t_hit) begin
          nxt = ST_IDLE; err_nxt = ERR_INIT_LO; fin_nxt = 1'b1;
        end
      end
      ST_WAIT_INIT: begin
        if (cfg_init) nxt = ST_STREAM;
        else if (t_hit) begin
          nxt = ST_IDLE; err_nxt = ERR_INIT_HI; fin_nxt = 1'b1;
        end
      end
      ST_STREAM:    if (sh_done && last_q) nxt = ST_WAIT_DONE;
      ST_WAIT_DONE: begin
        if (cfg_done) nxt = ST_RST_LO;
        else if (t_hit) begin
          nxt = ST_IDLE; err_nxt = ERR_DONE; fin_nxt = 1'b1;
        end
      end
      ST_RST_LO:    if (t_hit) nxt = ST_RST_HI;
      ST_RST_HI: begin
        if (t_hit) begin
          nxt = ST_IDLE; err_nxt = ERR_NONE; fin_nxt = 1'b1;
        end
      end
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      finished <= 1'b0;
      err_code <= ERR_NONE;
      last_q   <= 1'b0;
    end else begin
      state    <= nxt;
      finished <= fin_nxt;
      if (state == ST_IDLE && start) begin
        err_code <= ERR_NONE;
        last_q   <= 1'b0;
      end else begin
        err_code <= err_nxt;
        if (sh_load) last_q <= in_last;
      end
    end
  end

  assign in_ready = (state == ST_STREAM) && sh_idle && !last_q;
  assign sh_load  = in_valid && in_ready;

  cfg_shifter #(.HALF(HALF_CYC)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .din(in_data),
    .idle(sh_idle), .byte_done(sh_done), .sclk(sh_clk), .sdat(sh_dat)
  );

  assign rst_phase  = (state == ST_RST_LO) || (state == ST_RST_HI);
  assign busy       = (state != ST_IDLE);
  assign cfg_prog_n = (state != ST_PRG_LO);
  assign cfg_clk    = sh_clk || rst_phase;
  assign cfg_data   = sh_dat || (state == ST_RST_HI);

  p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_prog_quiet_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> !cfg_clk);

  p_ready_streaming_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && cfg_prog_n && cfg_init));

  p_finish_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> (!busy ##1 !finished));

  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(err_code));

endmodule

// File: tb/fpga_cfg_seq_test.sv
module fpga_cfg_seq_test;
  localparam int T_LO = 20, T_HI = 30, T_DN = 40, T_HALF = 3, T_RST = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic in_ready, cfg_prog_n, cfg_clk, cfg_data, busy, finished;
  logic [1:0] err_code;
  logic m_init = 1'b1, m_done = 1'b0;

  int vec = 0, bad = 0;

  fpga_cfg_seq #(.INIT_LO_TMO(T_LO), .INIT_HI_TMO(T_HI), .DONE_TMO(T_DN),
                 .HALF_CYC(T_HALF), .RST_CYC(T_RST)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .cfg_prog_n(cfg_prog_n), .cfg_init(m_init), .cfg_done(m_done),
    .cfg_clk(cfg_clk), .cfg_data(cfg_data), .busy(busy),
    .finished(finished), .err_code(err_code));

  always #5 clk = ~clk;

  // knobs written only by tasks
  int run_id = 0, lo_d = 5, hi_d = 5, dn_d = 5, exp_bits = 0;

  // target model and monitor, all at negedge
  int seen_id = 0, lo_cnt, hi_cnt, dn_cnt, bits, prog_low, rlo, rhi;
  int hi_run, hi_min, hi_max, ready_seen, fin_err;
  bit fin_seen, dchg;
  logic prev_clk = 1'b0, prev_dat = 1'b0;
  logic [7:0] cur;
  logic [7:0] cap [0:15];

  always @(negedge clk) begin
    if (seen_id != run_id) begin
      seen_id = run_id; m_init <= 1'b1; m_done <= 1'b0;
      lo_cnt = 0; hi_cnt = 0; dn_cnt = 0; bits = 0; prog_low = 0;
      rlo = 0; rhi = 0; hi_run = 0; hi_min = 1000; hi_max = 0;
      ready_seen = 0; fin_seen = 0; fin_err = 0; dchg = 0;
    end else begin
      if (!cfg_prog_n) begin
        prog_low++; hi_cnt = 0; bits = 0; dn_cnt = 0; m_done <= 1'b0;
        if (m_init) begin
          lo_cnt++;
          if (lo_d >= 0 && lo_cnt >= lo_d) m_init <= 1'b0;
        end
      end else if (!m_init) begin
        hi_cnt++;
        if (hi_d >= 0 && hi_cnt >= hi_d) m_init <= 1'b1;
      end
      if (cfg_prog_n && !m_done) begin
        if (cfg_clk && !prev_clk) begin
          cur = {cur[6:0], cfg_data};
          if (bits < 128) begin
            if (bits % 8 == 7) cap[bits / 8] = cur;
          end
          bits++;
        end
        if (cfg_clk) hi_run++;
        if (!cfg_clk && prev_clk && hi_run > 0) begin
          if (hi_run < hi_min) hi_min = hi_run;
          if (hi_run > hi_max) hi_max = hi_run;
          hi_run = 0;
        end
        if (cfg_clk && prev_clk && cfg_data != prev_dat) dchg = 1;
        if (exp_bits > 0 && bits >= exp_bits && dn_d >= 0) begin
          dn_cnt++;
          if (dn_cnt >= dn_d) m_done <= 1'b1;
        end
      end
      if (busy && cfg_prog_n && cfg_clk && m_done) begin
        if (!cfg_data) rlo++; else rhi++;
      end
      if (in_ready) ready_seen++;
      if (finished && !fin_seen) begin
        fin_seen = 1; fin_err = err_code;
        if (busy) dchg = 1;
      end
    end
    prev_clk = cfg_clk; prev_dat = cfg_data;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'h3C ^ 8'(i * 8'h47) ^ 8'h81;
  endfunction

  task automatic kick();
    run_id++;
    @(negedge clk); @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && cfg_prog_n == 1'b1, "R2", "busy/prog after start",
        {busy, cfg_prog_n}, 3);
    chk(err_code == 2'd0, "R9", "err cleared by start", err_code, 0);
    @(negedge clk);
    chk(cfg_prog_n == 1'b0, "R2", "prog asserted", cfg_prog_n, 0);
  endtask

  task automatic send(input int n, input int gap, input bit restart);
    for (int i = 0; i < n; i++) begin
      if (restart && i == 1) begin
        start = 1'b1; @(negedge clk); start = 1'b0;
      end
      in_data = pat(i); in_last = (i == n - 1); in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic wait_fin(input string req);
    int n = 0;
    while (!fin_seen && n < 20000) begin @(negedge clk); n++; end
    chk(fin_seen, req, "run finished (watchdog)", fin_seen, 1);
  endtask

  task automatic check_bytes(input int n, input string req);
    for (int i = 0; i < n; i++)
      chk(cap[i] == pat(i), req, $sformatf("byte %0d", i), cap[i], pat(i));
    chk(bits == 8 * n, req, "bit count", bits, 8 * n);
  endtask

  task automatic t_reset();
    chk(cfg_prog_n == 1'b1 && cfg_clk == 1'b0 && cfg_data == 1'b0, "R1",
        "pins after reset", {cfg_prog_n, cfg_clk, cfg_data}, 4);
    chk(busy == 1'b0 && in_ready == 1'b0 && finished == 1'b0, "R1",
        "status after reset", {busy, in_ready, finished}, 0);
    chk(err_code == 2'd0, "R1", "err after reset", err_code, 0);
  endtask

  task automatic t_normal();
    lo_d = 5; hi_d = 5; dn_d = 5; exp_bits = 32;
    kick();
    send(4, 0, 1'b0);
    wait_fin("R8");
    chk(fin_err == 0, "R8", "err ok", fin_err, 0);
    check_bytes(4, "R5");
    chk(hi_min == T_HALF && hi_max == T_HALF, "R5", "clk high width",
        hi_max, T_HALF);
    chk(!dchg, "R5", "data stable high / busy at finish", dchg, 0);
    chk(rlo == T_RST, "R8", "data-low reset phase", rlo, T_RST);
    chk(rhi == T_RST, "R8", "data-high reset phase", rhi, T_RST);
    @(negedge clk);
    chk(finished == 1'b0 && busy == 1'b0, "R9", "finished one cycle",
        {finished, busy}, 0);
  endtask

  task automatic t_init_lo_to();
    lo_d = -1; hi_d = 5; dn_d = 5; exp_bits = 0;
    kick();
    wait_fin("R3");
    chk(fin_err == 1, "R3", "err code", fin_err, 1);
    chk(prog_low == T_LO, "R3", "prog low cycles", prog_low, T_LO);
    chk(ready_seen == 0, "R6", "no ready outside stream", ready_seen, 0);
  endtask

  task automatic t_init_hi_to();
    lo_d = 4; hi_d = -1; dn_d = 5; exp_bits = 0;
    kick();
    wait_fin("R4");
    chk(fin_err == 2, "R4", "err code", fin_err, 2);
    chk(ready_seen == 0, "R6", "no ready without init high", ready_seen, 0);
  endtask

  task automatic t_done_to();
    lo_d = 3; hi_d = 3; dn_d = -1; exp_bits = 16;
    kick();
    send(2, 0, 1'b0);
    wait_fin("R7");
    chk(fin_err == 3, "R7", "err code", fin_err, 3);
    chk(rlo == 0 && rhi == 0, "R7", "no data-pin reset", rlo + rhi, 0);
    repeat (6) @(negedge clk);
    chk(err_code == 2'd3 && busy == 1'b0, "R9", "err holds when idle",
        err_code, 3);
  endtask

  task automatic t_stall_restart();
    lo_d = 6; hi_d = 2; dn_d = 3; exp_bits = 24;
    kick();
    send(3, 7, 1'b1);
    wait_fin("R10");
    chk(fin_err == 0, "R10", "stray start no effect", fin_err, 0);
    check_bytes(3, "R6");
    chk(rlo == T_RST && rhi == T_RST, "R10", "single reset sequence",
        rlo + rhi, 2 * T_RST);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_init_lo_to();
    t_init_hi_to();
    t_done_to();
    t_stall_restart();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #1500000;
    bad++; vec++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule